// File: doc/BRIEF.md
# Round-Robin Sensor Polling Master

This block is the master end of a shared half-duplex link on which nothing
talks unless the master has asked it to. It walks through slave addresses
0 to `N_SLAVES-1` in rising order and wraps back to 0. For each address it
requests a poll frame. The poll is broadcast to every slave, but only the slave
with that address may answer. Once the link reports that the poll has gone out
completely, the block opens a listen window of a programmable number of cycles.

A reply counts only if it arrives inside that window and carries the polled
address as its source. A valid reply sets that slave's presence bit and is
handed out for one cycle. If the window closes with no valid reply, the
slave's bit is cleared. Either way the exchange ends there and the next
address is polled. Because only the master ever starts a transfer, two
senders never collide on the link.

The controller has four states. In IDLE it waits for `poll_en`. In SEND it
holds `poll_req` until `poll_ack`. In WAIT it waits for `poll_sent`. In LISTEN
it runs the reply window. The transitions are:

- start: IDLE to SEND, when `poll_en` is high.
- accept: SEND to WAIT, on `poll_ack`.
- sent: WAIT to LISTEN, on `poll_sent`, which loads the window counter.
- reply: LISTEN to SEND, or to IDLE when `poll_en` is low, on a valid reply.
- expire: LISTEN to SEND, or to IDLE when `poll_en` is low, on the last window cycle with no valid reply.

Top module: `sensor_poll_master`

## Requirements
- R1: During and right after reset, `poll_req` is 0, `poll_addr` is 0, `presence` is all zeros and `rep_valid` is 0.
- R2: While `poll_req` is 1 and `poll_ack` is 0, `poll_req` stays 1 on the next cycle and `poll_addr` does not change. After `poll_ack` is sampled, `poll_req` drops on the next cycle.
- R3: Each exchange polls the address after the previous one: 0, 1, ..., `N_SLAVES-1`, then 0 again. The first poll after reset is to address 0.
- R4: After `poll_sent` is sampled high, the listen window covers the next T sampled cycles, where T is `timeout_cycles`, or 1 when that value is 0. A reply accepted in cycle k of the window gives `rep_valid`=1 for exactly one cycle, in the cycle after k. That cycle also carries `rep_src` equal to the polled address and `rep_data` equal to the reply's `rx_data`.
- R5: A reply whose `rx_src` differs from the polled address is discarded, as is any reply sampled outside the listen window. A discarded reply produces no `rep_valid` and changes no presence bit.
- R6: A valid reply sets `presence[addr]` to 1. A window that closes without one clears `presence[addr]` to 0. The bit is visible in the cycle after the reply is sampled, or in the cycle after the last window cycle.
- R7: The next `poll_req` rises in the cycle right after the exchange ends, provided `poll_en` was 1 at the edge that ends it. No new poll starts earlier than that.
- R8: With `poll_en` low, an exchange already under way runs to its end, and then no poll is requested. When `poll_en` returns high, `poll_req` rises on the next cycle with the following address.
- R9: The window length is taken from `timeout_cycles` at the edge that samples `poll_sent`. Changing `timeout_cycles` during the window has no effect on that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| poll_en | input | 1 | Allows new exchanges to start |
| timeout_cycles | input | TMO_W | Reply window length in cycles (0 is treated as 1) |
| poll_req | output | 1 | Request to transmit a poll frame |
| poll_addr | output | ADDR_W | Address carried by the poll |
| poll_ack | input | 1 | Link has taken the poll request |
| poll_sent | input | 1 | One-cycle pulse: the poll frame has been fully sent |
| rx_valid | input | 1 | A reply frame is present this cycle |
| rx_src | input | ADDR_W | Source address of the reply |
| rx_data | input | DATA_W | Payload of the reply |
| rep_valid | output | 1 | One-cycle pulse for an accepted reply |
| rep_src | output | ADDR_W | Slave address of the accepted reply |
| rep_data | output | DATA_W | Payload of the accepted reply |
| presence | output | N_SLAVES | Per-slave presence bits, bit i belongs to address i |

## Verification
Every result of this block shows up one edge after the input that causes it:

- `rep_valid`, `rep_src`, `rep_data` and the presence bit follow one cycle after the reply is sampled.
- `poll_req` falls one cycle after `poll_ack`.
- `poll_req` rises again in the same cycle as the new presence bit.
- A window of T cycles begins on the sample after the one that saw `poll_sent`.

The bench drives inputs on falling edges. A behavioural model advances on each rising edge using the same sampled inputs, and every output is compared with the model on the following falling edge. Directed checks are placed at the exact cycle: a reply in the last window slot, one slot too late, a wrong source, a reply during WAIT, a window of 1, and a mid-window change of the timeout.

// File: rtl/spm_pkg.sv
package spm_pkg;

    // Controller states of the polling master
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // waiting for poll_en
        ST_SEND   = 2'd1,   // poll requested, waiting for the link to take it
        ST_WAIT   = 2'd2,   // poll in flight, waiting for end of frame
        ST_LISTEN = 2'd3    // reply window open
    } spm_state_e;

endpackage

// File: rtl/spm_addr_seq.sv
module spm_addr_seq #(
    parameter int N_SLAVES = 16,
    parameter int ADDR_W   = $clog2(N_SLAVES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_SLAVES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (adv) begin
            if (addr == LAST_ADDR) begin
                addr <= '0;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && addr != LAST_ADDR) |=> addr == $past(addr) + 1'b1);

    // R3
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && addr == LAST_ADDR) |=> addr == '0);

endmodule

// File: rtl/spm_window_timer.sv
module spm_window_timer #(
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMO_W-1:0] load_val,
    input  logic             run,
    output logic             last
);

    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? TMO_W'(1) : load_val;
        end else if (run && cnt > TMO_W'(1)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt <= TMO_W'(1));

    // R4: a running window always holds a live count
    run_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt != '0);

endmodule

// File: rtl/spm_presence.sv
module spm_presence #(
    parameter int N_SLAVES = 16,
    parameter int ADDR_W   = $clog2(N_SLAVES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [ADDR_W-1:0]   idx,
    output logic [N_SLAVES-1:0] bits
);

    for (genvar g = 0; g < N_SLAVES; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits[g] <= 1'b0;
            end else if (idx == SLOT) begin
                if (set_en) begin
                    bits[g] <= 1'b1;
                end else if (clr_en) begin
                    bits[g] <= 1'b0;
                end
            end
        end
    end

    // R6
    set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !clr_en);

    // R6
    set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> bits[$past(idx)]);

    // R6
    clr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !bits[$past(idx)]);

endmodule

// File: rtl/sensor_poll_master.sv
module sensor_poll_master
    import spm_pkg::*;
#(
    parameter int N_SLAVES = 16,
    parameter int DATA_W   = 8,
    parameter int TMO_W    = 12,
    parameter int ADDR_W   = $clog2(N_SLAVES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                poll_en,
    input  logic [TMO_W-1:0]    timeout_cycles,
    output logic                poll_req,
    output logic [ADDR_W-1:0]   poll_addr,
    input  logic                poll_ack,
    input  logic                poll_sent,
    input  logic                rx_valid,
    input  logic [ADDR_W-1:0]   rx_src,
    input  logic [DATA_W-1:0]   rx_data,
    output logic                rep_valid,
    output logic [ADDR_W-1:0]   rep_src,
    output logic [DATA_W-1:0]   rep_data,
    output logic [N_SLAVES-1:0] presence
);

    spm_state_e        state_q, state_d;
    logic [ADDR_W-1:0] cur_addr;
    logic              tmr_load, tmr_run, tmr_last;
    logic              hit, expire, done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (poll_en)   state_d = ST_SEND;
            ST_SEND:   if (poll_ack)  state_d = ST_WAIT;
            ST_WAIT:   if (poll_sent) state_d = ST_LISTEN;
            ST_LISTEN: if (done)      state_d = poll_en ? ST_SEND : ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // outputs and control strobes
    always_comb begin
        poll_req = 1'b0;
        tmr_load = 1'b0;
        tmr_run  = 1'b0;
        hit      = 1'b0;
        expire   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SEND:  poll_req = 1'b1;
            ST_WAIT:  tmr_load = poll_sent;
            ST_LISTEN: begin
                tmr_run = 1'b1;
                hit     = rx_valid && (rx_src == cur_addr);
                expire  = !hit && tmr_last;
            end
            default: ;
        endcase
        done = hit || expire;
    end

    assign poll_addr = cur_addr;

    // accepted reply hand-off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_valid <= 1'b0;
            rep_src   <= '0;
            rep_data  <= '0;
        end else begin
            rep_valid <= hit;
            if (hit) begin
                rep_src  <= cur_addr;
                rep_data <= rx_data;
            end
        end
    end

    spm_addr_seq #(
        .N_SLAVES (N_SLAVES),
        .ADDR_W   (ADDR_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (done),
        .addr  (cur_addr)
    );

    spm_window_timer #(
        .TMO_W (TMO_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (timeout_cycles),
        .run      (tmr_run),
        .last     (tmr_last)
    );

    spm_presence #(
        .N_SLAVES (N_SLAVES),
        .ADDR_W   (ADDR_W)
    ) u_pres (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (hit),
        .clr_en (expire),
        .idx    (cur_addr),
        .bits   (presence)
    );

    // R2
    poll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && !poll_ack) |=> (poll_req && $stable(poll_addr)));

    // R2
    poll_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && poll_ack) |=> !poll_req);

    // R4
    rep_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |=> !rep_valid);

    // R6
    rep_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> presence[rep_src]);

    // R7
    rep_next_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> (poll_req == $past(poll_en)));

endmodule

// File: tb/sensor_poll_master_bench.sv
`timescale 1ns/1ps
module sensor_poll_master_bench;

    localparam int N  = 16;
    localparam int DW = 8;
    localparam int TW = 12;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          poll_en = 1'b0;
    logic [TW-1:0] timeout_cycles = TW'(5);
    logic          poll_req;
    logic [AW-1:0] poll_addr;
    logic          poll_ack = 1'b0;
    logic          poll_sent = 1'b0;
    logic          rx_valid = 1'b0;
    logic [AW-1:0] rx_src = '0;
    logic [DW-1:0] rx_data = '0;
    logic          rep_valid;
    logic [AW-1:0] rep_src;
    logic [DW-1:0] rep_data;
    logic [N-1:0]  presence;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    sensor_poll_master #(.N_SLAVES(N), .DATA_W(DW), .TMO_W(TW)) u_sensor_poll_master (
        .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .timeout_cycles(timeout_cycles),
        .poll_req(poll_req), .poll_addr(poll_addr), .poll_ack(poll_ack),
        .poll_sent(poll_sent), .rx_valid(rx_valid), .rx_src(rx_src), .rx_data(rx_data),
        .rep_valid(rep_valid), .rep_src(rep_src), .rep_data(rep_data), .presence(presence)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 send, 2 wait, 3 listen
    int      m_phase = 0;
    int      m_addr  = 0;
    int      m_cnt   = 0;
    bit      m_pres [N];
    bit      m_rep_v = 0;
    int      m_rep_src = 0;
    int      m_rep_data = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_addr = 0; m_cnt = 0; m_rep_v = 0;
            m_rep_src = 0; m_rep_data = 0;
            foreach (m_pres[i]) m_pres[i] = 0;
        end else begin
            m_rep_v = 0;
            case (m_phase)
                0: if (poll_en) m_phase = 1;
                1: if (poll_ack) m_phase = 2;
                2: if (poll_sent) begin
                       m_phase = 3;
                       m_cnt = (timeout_cycles == 0) ? 1 : int'(timeout_cycles);
                   end
                default: begin
                    if (rx_valid && int'(rx_src) == m_addr) begin
                        m_pres[m_addr] = 1;
                        m_rep_v = 1; m_rep_src = m_addr; m_rep_data = int'(rx_data);
                        m_addr = (m_addr + 1) % N;
                        m_phase = poll_en ? 1 : 0;
                    end else if (m_cnt <= 1) begin
                        m_pres[m_addr] = 0;
                        m_addr = (m_addr + 1) % N;
                        m_phase = poll_en ? 1 : 0;
                    end else begin
                        m_cnt = m_cnt - 1;
                    end
                end
            endcase
        end
    end

    // compare against the reference on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            int mp;
            mp = 0;
            foreach (m_pres[i]) if (m_pres[i]) mp |= (1 << i);
            chk(poll_req == (m_phase == 1), "R2 model poll_req", int'(poll_req), int'(m_phase == 1));
            chk(int'(poll_addr) == m_addr, "R3 model poll_addr", int'(poll_addr), m_addr);
            chk(int'(presence) == mp, "R6 model presence", int'(presence), mp);
            chk(rep_valid == m_rep_v, "R4 model rep_valid", int'(rep_valid), int'(m_rep_v));
            if (m_rep_v) begin
                chk(int'(rep_src) == m_rep_src, "R4 model rep_src", int'(rep_src), m_rep_src);
                chk(int'(rep_data) == m_rep_data, "R4 model rep_data", int'(rep_data), m_rep_data);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done_flag) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_poll();
        while (!poll_req) @(negedge clk);
    endtask

    // serve one exchange from the link/slave side
    task automatic serve(input int hold, input bit reply, input int delay,
                         input bit wrong_first, input bit stray, input int tmo_after,
                         input bit expect_ok, input int exp_addr);
        int a;
        wait_poll();
        a = int'(poll_addr);
        chk(a == exp_addr, "R3 poll order", a, exp_addr);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(poll_req && int'(poll_addr) == a, "R2 hold without ack", int'(poll_addr), a);
        end
        poll_ack = 1'b1;
        @(negedge clk);
        poll_ack = 1'b0;
        chk(!poll_req, "R2 drop after ack", int'(poll_req), 0);
        if (stray) begin
            rx_valid = 1'b1; rx_src = AW'(a); rx_data = 8'h5A;
            @(negedge clk);
            rx_valid = 1'b0;
            chk(!rep_valid, "R5 reply before window", int'(rep_valid), 0);
        end
        @(negedge clk);
        poll_sent = 1'b1;
        @(negedge clk);
        poll_sent = 1'b0;
        if (tmo_after >= 0) timeout_cycles = TW'(tmo_after);
        for (int d = 0; d < delay; d++) @(negedge clk);
        if (wrong_first) begin
            rx_valid = 1'b1; rx_src = AW'(a ^ 1); rx_data = 8'h33;
            @(negedge clk);
            rx_valid = 1'b0;
            chk(!rep_valid, "R5 wrong source", int'(rep_valid), 0);
        end
        if (reply) begin
            rx_valid = 1'b1; rx_src = AW'(a); rx_data = DW'(8'hA0 + a);
            @(negedge clk);
            rx_valid = 1'b0;
            if (expect_ok) begin
                chk(rep_valid && int'(rep_src) == a && rep_data == DW'(8'hA0 + a),
                    "R4 reply handed out", int'(rep_src), a);
                chk(poll_req == poll_en, "R7 next poll follows", int'(poll_req), int'(poll_en));
            end else begin
                chk(!rep_valid, "R5 reply discarded", int'(rep_valid), 0);
            end
        end
    endtask

    task automatic pres_after(input int a, input bit exp);
        wait_poll();
        chk(presence[a] == exp, "R6 presence bit", int'(presence[a]), int'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!poll_req && poll_addr == 0 && presence == 0 && !rep_valid, "R1 in reset",
            int'(presence), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!poll_req && poll_addr == 0 && presence == 0 && !rep_valid, "R1 after reset",
            int'(poll_req), 0);
        poll_en = 1'b1;

        serve(0, 1, 0, 0, 0, -1, 1, 0);  pres_after(0, 1);   // R4 first slot
        serve(3, 1, 4, 0, 0, -1, 1, 1);  pres_after(1, 1);   // R4 last slot, R2 hold
        serve(0, 1, 5, 0, 0, -1, 0, 2);  pres_after(2, 0);   // R5 one slot late
        serve(0, 0, 0, 1, 0, -1, 0, 3);  pres_after(3, 0);   // R5 wrong source only
        serve(1, 1, 0, 1, 0, -1, 1, 4);  pres_after(4, 1);   // wrong then right
        serve(0, 0, 0, 0, 1, -1, 0, 5);  pres_after(5, 0);   // R5 stray during WAIT
        serve(0, 1, 3, 0, 0, 1, 1, 6);   pres_after(6, 1);   // R9 change mid-window
        timeout_cycles = TW'(0);
        serve(0, 1, 1, 0, 0, -1, 0, 7);  pres_after(7, 0);   // R4 zero means one
        timeout_cycles = TW'(3);
        for (int a = 8; a < 16; a++) begin
            serve(0, (a % 2) == 0, a % 3, 0, 0, -1, 1, a);
            pres_after(a, (a % 2) == 0);
        end
        serve(0, 0, 0, 0, 0, -1, 0, 0);  pres_after(0, 0);   // R3 wrap, R6 clear

        // R8: disable during an exchange
        wait_poll();
        poll_en = 1'b0;
        serve(0, 1, 0, 0, 0, -1, 1, 1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!poll_req, "R8 no poll while disabled", int'(poll_req), 0);
        end
        poll_en = 1'b1;
        @(negedge clk);
        chk(poll_req && poll_addr == 2, "R8 resume at next address", int'(poll_addr), 2);
        repeat (4) @(negedge clk);

        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule